// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit load/store processor that shows sixteen registers to software at any time. Some of those sixteen are swapped for private copies depending on the processor's current operating mode, so that an exception handler has its own stack pointer and link register, and the fast-interrupt handler also has its own working registers. Each port of the block takes a 5-bit mode code and a 4-bit register index. A mapping stage turns that pair into one physical storage slot.

There are three combinational read ports and one write port that updates on the clock edge. Index 15 is the program counter, and the counter is kept outside this block. A read at index 15 returns the counter value that the top level supplies on `pc_value`. A write at index 15 is dropped. The storage holds thirty physical registers: fifteen shared user registers, seven registers private to the fast-interrupt mode, and two private registers for each of the four other exception modes.

Top module: `rf_banked_regs`

## Requirements
- R1: After reset every stored register reads as zero, for every mode and every index from 0 to 14.
- R2: A write with `wr_en` high stores `wr_data` at the rising clock edge into the slot selected by `wr_mode`/`wr_idx`. From then on a read of that mode and index returns it. Reads are combinational.
- R3: Indices 0 to 7 map to the same shared storage in every mode. Indices 8 to 12 map to shared storage in every mode except fast-interrupt (mode code 10001).
- R4: In fast-interrupt mode (10001), indices 8 to 14 map to seven private registers that no other mode can reach.
- R5: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 map to a private pair for each mode. Each of the four pairs is separate from the others and from the user copies.
- R6: System mode (11111) uses exactly the user-mode (10000) mapping.
- R7: Any mode code that is not one of the seven listed codes uses the user-mode mapping.
- R8: A read at index 15 returns `pc_value` in any mode. A write at index 15 changes no stored register.
- R9: A read of the slot that is being written in the same cycle returns the value held before the write.
- R10: The three read ports are independent. Each one resolves its own mode and index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears all storage |
| pc_value | input | 32 | Program counter value returned for index-15 reads |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 5 | Mode code for the write |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| ra_mode | input | 5 | Mode code, read port A |
| ra_idx | input | 4 | Register index, read port A |
| ra_data | output | 32 | Read data, port A |
| rb_mode | input | 5 | Mode code, read port B |
| rb_idx | input | 4 | Register index, read port B |
| rb_data | output | 32 | Read data, port B |
| rc_mode | input | 5 | Mode code, read port C |
| rc_idx | input | 4 | Register index, read port C |
| rc_data | output | 32 | Read data, port C |

## Verification
The assertions check on every cycle the relations between ports that hold at all times. An index-15 read equals `pc_value`. Two ports that read the same index in user and system mode, in a user and an unrecognised mode, or at an index below 8 in any pair of modes, see the same data. A register written in one cycle reads back the written value in the next. The bench's scenarios are needed for the rest: the reset contents, which private copies stay separate from which, the dropped index-15 write, and the old value returned when a slot is read and written in the same cycle. The bench shows these by comparing randomised mixes of writes and reads across all modes against its own bank model.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;
  localparam int IDX_W   = 4;
  localparam int MODE_W  = 5;
  localparam int N_SHARE = 15;
  localparam int N_FIQ   = 7;
  localparam int N_PAIR  = 2;
  localparam int N_XMODE = 4;
  localparam int N_PHYS  = N_SHARE + N_FIQ + N_PAIR * N_XMODE;
  localparam int PHYS_W  = $clog2(N_PHYS);
  localparam int FIQ_BASE  = N_SHARE;
  localparam int PAIR_BASE = N_SHARE + N_FIQ;

  localparam logic [MODE_W-1:0] M_USER = 5'b10000;
  localparam logic [MODE_W-1:0] M_FAST = 5'b10001;
  localparam logic [MODE_W-1:0] M_INTR = 5'b10010;
  localparam logic [MODE_W-1:0] M_SUPV = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABRT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UNDF = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYST = 5'b11111;

  typedef enum logic [2:0] {
    BK_USER = 3'd0, BK_FAST = 3'd1, BK_INTR = 3'd2,
    BK_SUPV = 3'd3, BK_ABRT = 3'd4, BK_UNDF = 3'd5
  } bank_e;

  // System and unknown codes share the user bank.
  function automatic bank_e bank_of(logic [MODE_W-1:0] m);
    case (m)
      M_FAST:  return BK_FAST;
      M_INTR:  return BK_INTR;
      M_SUPV:  return BK_SUPV;
      M_ABRT:  return BK_ABRT;
      M_UNDF:  return BK_UNDF;
      default: return BK_USER;
    endcase
  endfunction

  // Physical slot for a (bank, index) pair; index 15 is handled by the caller.
  function automatic logic [PHYS_W-1:0] phys_of(bank_e b, logic [IDX_W-1:0] i);
    int slot;
    slot = int'(i);
    if (b == BK_FAST && i >= 4'd8 && i <= 4'd14)
      slot = FIQ_BASE + int'(i) - 8;
    else if (b != BK_USER && b != BK_FAST && (i == 4'd13 || i == 4'd14))
      slot = PAIR_BASE + N_PAIR * (int'(b) - int'(BK_INTR)) + (int'(i) - 13);
    return PHYS_W'(slot);
  endfunction
endpackage

// File: rtl/rf_port_map.sv
module rf_port_map
  import rf_bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  bank_e bank;
  always_comb begin
    bank  = bank_of(mode);
    phys  = phys_of(bank, idx);
    is_pc = (idx == 4'd15);
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DW  = 32,
  parameter int NE  = 30,
  parameter int AW  = 5,
  parameter int NRD = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] mem [NE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NE; k++) mem[k] <= '0;
    end else if (we && int'(waddr) < NE) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (int'(raddr[p]) < NE) ? mem[raddr[p]] : '0;
  end
endmodule

// File: rtl/rf_banked_regs.sv
module rf_banked_regs
  import rf_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pc_value,
  input  logic              wr_en,
  input  logic [4:0]        wr_mode,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        ra_mode,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [4:0]        rb_mode,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic [4:0]        rc_mode,
  input  logic [3:0]        rc_idx,
  output logic [DATA_W-1:0] rc_data
);
  localparam int NRD = 3;

  logic [NRD-1:0][MODE_W-1:0] rd_mode;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][PHYS_W-1:0] rd_phys;
  logic [NRD-1:0]             rd_is_pc;
  logic [NRD-1:0][DATA_W-1:0] rd_raw;
  logic [NRD-1:0][DATA_W-1:0] rd_out;

  logic [PHYS_W-1:0] wr_phys;
  logic              wr_is_pc;
  logic              wr_commit;   // write actually reaches storage

  assign rd_mode = {rc_mode, rb_mode, ra_mode};
  assign rd_idx  = {rc_idx,  rb_idx,  ra_idx};

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    rf_port_map u_map (
      .mode (rd_mode[p]),
      .idx  (rd_idx[p]),
      .phys (rd_phys[p]),
      .is_pc(rd_is_pc[p])
    );
    assign rd_out[p] = rd_is_pc[p] ? pc_value : rd_raw[p];
  end

  rf_port_map u_wmap (
    .mode (wr_mode),
    .idx  (wr_idx),
    .phys (wr_phys),
    .is_pc(wr_is_pc)
  );

  assign wr_commit = wr_en && !wr_is_pc;

  rf_store #(.DW(DATA_W), .NE(N_PHYS), .AW(PHYS_W), .NRD(NRD)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_commit),
    .waddr(wr_phys),
    .wdata(wr_data),
    .raddr(rd_phys),
    .rdata(rd_raw)
  );

  assign ra_data = rd_out[0];
  assign rb_data = rd_out[1];
  assign rc_data = rd_out[2];
endmodule

// File: rtl/rf_bank_chk.sv
module rf_bank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pc_value,
  input logic              wr_en,
  input logic [4:0]        wr_mode,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [4:0]        ra_mode,
  input logic [3:0]        ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [4:0]        rb_mode,
  input logic [3:0]        rb_idx,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_commit
);
  function automatic logic known(logic [4:0] m);
    return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                     5'b10111, 5'b11011, 5'b11111};
  endfunction

  p_pc_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == 4'd15) |-> (ra_data == pc_value));

  p_pc_write_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == 4'd15) |-> !wr_commit);

  p_low_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx < 4'd8 && rb_idx == ra_idx) |-> (ra_data == rb_data));

  p_sys_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 5'b11111 && rb_mode == 5'b10000 && rb_idx == ra_idx)
      |-> (ra_data == rb_data));

  p_unknown_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!known(ra_mode) && rb_mode == 5'b10000 && rb_idx == ra_idx)
      |-> (ra_data == rb_data));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 4'd15 &&
     ra_mode == $past(wr_mode) && ra_idx == $past(wr_idx))
      |-> (ra_data == $past(wr_data)));
endmodule

bind rf_banked_regs rf_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_value(pc_value),
  .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
  .ra_mode(ra_mode), .ra_idx(ra_idx), .ra_data(ra_data),
  .rb_mode(rb_mode), .rb_idx(rb_idx), .rb_data(rb_data),
  .wr_commit(wr_commit)
);

// File: tb/tb_rf_banked_regs.sv
module tb_rf_banked_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_value = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_mode = 5'b10000;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  ra_mode = 5'b10000, rb_mode = 5'b10000, rc_mode = 5'b10000;
  logic [3:0]  ra_idx = '0, rb_idx = '0, rc_idx = '0;
  logic [31:0] ra_data, rb_data, rc_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rf_banked_regs dut (
    .clk(clk), .rst_n(rst_n), .pc_value(pc_value),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_mode(ra_mode), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_mode(rb_mode), .rb_idx(rb_idx), .rb_data(rb_data),
    .rc_mode(rc_mode), .rc_idx(rc_idx), .rc_data(rc_data)
  );

  // Bench model: user copies, fast-mode copies of 8..14, per-mode 13/14 pairs.
  logic [31:0] m_user [15];
  logic [31:0] m_fast [7];
  logic [31:0] m_pair [4][2];

  function automatic int pair_sel(logic [4:0] m);
    if (m == 5'b10010) return 0;
    if (m == 5'b10011) return 1;
    if (m == 5'b10111) return 2;
    if (m == 5'b11011) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] model_rd(logic [4:0] m, logic [3:0] i);
    int ps;
    ps = pair_sel(m);
    if (i == 4'd15) return pc_value;
    if (m == 5'b10001 && i >= 4'd8) return m_fast[int'(i) - 8];
    if (ps >= 0 && i >= 4'd13) return m_pair[ps][int'(i) - 13];
    return m_user[i];
  endfunction

  task automatic model_wr(logic [4:0] m, logic [3:0] i, logic [31:0] d);
    int ps;
    ps = pair_sel(m);
    if (i == 4'd15) return;
    if (m == 5'b10001 && i >= 4'd8) m_fast[int'(i) - 8] = d;
    else if (ps >= 0 && i >= 4'd13) m_pair[ps][int'(i) - 13] = d;
    else m_user[i] = d;
  endtask

  function automatic logic [4:0] pick_mode(int n);
    case (n % 9)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010;
      3: return 5'b10011; 4: return 5'b10111; 5: return 5'b11011;
      6: return 5'b11111; 7: return 5'b00110;
      default: return 5'b10100;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // Compare all three ports against the model (state before any pending write).
  task automatic check_ports(string req);
    check(req, ra_data, model_rd(ra_mode, ra_idx));
    check(req, rb_data, model_rd(rb_mode, rb_idx));
    check(req, rc_data, model_rd(rc_mode, rc_idx));
  endtask

  // Drive at negedge, check reads, then commit the write at the posedge.
  task automatic step(string req);
    #1;
    check_ports(req);
    @(posedge clk);
    if (wr_en) model_wr(wr_mode, wr_idx, wr_data);
    @(negedge clk);
  endtask

  task automatic set_rd(logic [4:0] ma, logic [3:0] ia, logic [4:0] mb,
                        logic [3:0] ib, logic [4:0] mc, logic [3:0] ic);
    ra_mode = ma; ra_idx = ia; rb_mode = mb; rb_idx = ib; rc_mode = mc; rc_idx = ic;
  endtask

  task automatic set_wr(logic e, logic [4:0] m, logic [3:0] i, logic [31:0] d);
    wr_en = e; wr_mode = m; wr_idx = i; wr_data = d;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 15; k++) m_user[k] = '0;
    for (int k = 0; k < 7; k++) m_fast[k] = '0;
    for (int k = 0; k < 4; k++) begin m_pair[k][0] = '0; m_pair[k][1] = '0; end
    pc_value = 32'h0000_1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every mode, every stored index reads zero after reset
    for (int md = 0; md < 7; md++) begin
      for (int ix = 0; ix < 15; ix++) begin
        set_rd(pick_mode(md), 4'(ix), pick_mode(md), 4'(ix), pick_mode(md), 4'(ix));
        #1;
        check("R1", ra_data, 32'h0);
      end
    end

    // R4/R5: private copies separate from user copy and from each other
    set_wr(1'b1, 5'b10000, 4'd13, 32'hAAAA_0013); step("R2");
    set_wr(1'b1, 5'b10010, 4'd13, 32'hBBBB_0013); step("R5");
    set_wr(1'b1, 5'b10011, 4'd13, 32'hCCCC_0013); step("R5");
    set_wr(1'b1, 5'b10001, 4'd9,  32'hDDDD_0009); step("R4");
    set_wr(1'b0, 5'b10000, 4'd0, '0);
    set_rd(5'b10000, 4'd13, 5'b10010, 4'd13, 5'b10011, 4'd13); step("R5");
    set_rd(5'b10111, 4'd13, 5'b11011, 4'd13, 5'b10001, 4'd13); step("R5");
    set_rd(5'b10000, 4'd9, 5'b10001, 4'd9, 5'b10010, 4'd9); step("R4");

    // R8: index-15 write dropped; read returns pc_value
    pc_value = 32'hCAFE_F00C;
    set_wr(1'b1, 5'b10001, 4'd15, 32'h1234_5678); step("R8");
    set_wr(1'b0, 5'b10000, 4'd0, '0);
    set_rd(5'b10000, 4'd15, 5'b10001, 4'd15, 5'b10001, 4'd8); step("R8");
    set_rd(5'b10000, 4'd14, 5'b10001, 4'd14, 5'b10001, 4'd8); step("R8");

    // R9: read the slot being written this cycle returns the old value
    set_wr(1'b1, 5'b10011, 4'd14, 32'h0BAD_BEEF);
    set_rd(5'b10011, 4'd14, 5'b10011, 4'd14, 5'b10011, 4'd14); step("R9");
    set_wr(1'b0, 5'b10000, 4'd0, '0); step("R9");

    // R6/R7: system and unknown codes alias user storage
    set_wr(1'b1, 5'b11111, 4'd14, 32'h5555_0E0E); step("R6");
    set_wr(1'b1, 5'b00110, 4'd12, 32'h7777_0C0C); step("R7");
    set_wr(1'b0, 5'b10000, 4'd0, '0);
    set_rd(5'b10000, 4'd14, 5'b10000, 4'd12, 5'b11111, 4'd12); step("R6");
    set_rd(5'b10100, 4'd14, 5'b00110, 4'd14, 5'b10010, 4'd12); step("R7");

    // R2/R3/R10: constrained-random writes and reads across all modes
    for (int v = 0; v < 3000; v++) begin
      pc_value = $urandom;
      set_wr(($urandom % 4) != 0, pick_mode(int'($urandom % 9)), 4'($urandom), $urandom);
      set_rd(pick_mode(int'($urandom % 9)), 4'($urandom),
             pick_mode(int'($urandom % 9)), 4'($urandom),
             pick_mode(int'($urandom % 9)), 4'($urandom));
      if ((v % 5) == 0) begin ra_mode = wr_mode; ra_idx = wr_idx; end
      step("R10");
    end
    set_wr(1'b0, 5'b10000, 4'd0, '0);

    // R3: low indices agree in every mode after the random run
    for (int ix = 0; ix < 13; ix++) begin
      set_rd(5'b10000, 4'(ix), 5'b10011, 4'(ix), 5'b11011, 4'(ix)); step("R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule